// File: doc/BRIEF.md
# Multi-hart machine timer

This block keeps a single free-running 64-bit time count shared by all harts, plus one 64-bit compare value for each hart. Each hart has an interrupt line. The line goes high once the shared count has reached or passed that hart's compare value. The count advances by one on every cycle in which `tick` is high. Software can overwrite the count.

All state sits in a 0x8000-byte register window on a 32-bit register bus. A request is a single cycle of `req_valid`. Read data and the error flag answer combinationally in that same cycle, and writes take effect at the clock edge that ends the request.

Each 64-bit value is reached as two 32-bit halves. The hart compare slots start at offset 0, one every 8 bytes. The count takes the last 8-byte slot of the window. The number of harts is a parameter, and the bench uses 4.

Top module: `hart_timer`

## Requirements
- R1: After reset the count is 0, every compare value is 0xFFFFFFFF_FFFFFFFF, and every interrupt line is low.
- R2: While `tick` is high and no count write is in progress, the count goes up by exactly one per cycle. With `tick` low and no write, the count holds its value.
- R3: The count is at offsets 0x7FF8 (bits 31:0) and 0x7FFC (bits 63:32). A write to one half leaves the other half unchanged.
- R4: The compare value for hart h is at offset 8*h (bits 31:0) and 8*h+4 (bits 63:32). Offset bit 2 selects the half, and offset bits 14:3 give the slot index. A write to one half leaves the other half unchanged.
- R5: Interrupt line h is high when the count is greater than or equal to compare value h, and low otherwise, judged as unsigned values. The line is registered, so it reflects the values present one cycle earlier.
- R6: When a count write and `tick` occur in the same cycle, the written value is kept and the tick is lost.
- R7: A request at an offset of 0x8000 or above raises `rsp_err` in the same cycle and returns read data 0. A write to such an offset changes no state.
- R8: A compare slot whose index is at or above NHARTS reads as 0 and ignores writes, and it raises no error.
- R9: Read data for a valid in-window request is present on `rsp_rdata` in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one increment per high cycle |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset into the window (AW >= 16) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Out-of-window access |
| tmr_irq | output | NHARTS | Per-hart timer interrupt |

## Verification
The assertions assume two things about the inputs: requests are 32-bit aligned, and `tick` is already in the clock domain, so any cycle may carry a tick, a write, or both. The stimulus drives every input on the falling edge. It holds `tick` low except in the increment and priority scenarios, so that the bench can predict the count exactly from its own writes. Each interrupt check is timed from a known count or compare write, which keeps the one-cycle registered latency visible.

// File: rtl/hart_timer.sv
module hart_timer #(
  parameter int NHARTS = 4,
  parameter int AW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NHARTS-1:0] tmr_irq
);
  localparam int WB = 15;
  localparam logic [11:0] TIME_SLOT = 12'hFFF;

  logic [63:0] cnt;
  logic [63:0] cmp [NHARTS];
  logic [63:0] sel;

  wire        in_win  = (req_addr >> WB) == '0;
  wire [11:0] slot    = req_addr[14:3];
  wire        hi      = req_addr[2];
  wire        is_time = slot == TIME_SLOT;
  wire        wr      = req_valid & req_write & in_win;

  assign rsp_err = req_valid & ~in_win;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (wr && is_time)    cnt <= hi ? {req_wdata, cnt[31:0]} : {cnt[63:32], req_wdata};
    else if (tick)             cnt <= cnt + 64'd1;
  end

  for (genvar g = 0; g < NHARTS; g++) begin : g_hart
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp[g]     <= '1;
        tmr_irq[g] <= 1'b0;
      end else begin
        if (wr && !is_time && slot == 12'(g))
          cmp[g] <= hi ? {req_wdata, cmp[g][31:0]} : {cmp[g][63:32], req_wdata};
        tmr_irq[g] <= cnt >= cmp[g];
      end
    end
  end

  always_comb begin
    sel = '0;
    if (req_valid && in_win) begin
      if (is_time) sel = cnt;
      else
        for (int h = 0; h < NHARTS; h++)
          if (slot == 12'(h)) sel = cmp[h];
    end
    rsp_rdata = hi ? sel[63:32] : sel[31:0];
  end
endmodule

// File: rtl/hart_timer_chk.sv
module hart_timer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_err,
  input logic [63:0]   cnt,
  input logic [63:0]   cmp0,
  input logic          irq0
);
  wire wreq = req_valid & req_write;

  assert_err_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> req_valid);

  assert_err_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq && rsp_err) |=> cnt == $past(cnt) + 64'($past(tick)));

  assert_low_keeps_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq && !rsp_err && req_addr[14:2] == 13'h1FFE) |=> cnt[63:32] == $past(cnt[63:32]));

  assert_high_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq && !rsp_err && req_addr[14:2] == 13'h1FFF) |=> cnt[31:0] == $past(cnt[31:0]));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wreq) |=> $stable(cnt));

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wreq) |=> cnt == $past(cnt) + 64'd1);

  assert_irq_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq0 == ($past(cnt) >= $past(cmp0)));
endmodule

bind hart_timer hart_timer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .rsp_err(rsp_err),
  .cnt(cnt), .cmp0(cmp[0]), .irq0(tmr_irq[0])
);

// File: tb/tb_hart_timer.sv
`timescale 1ns/1ps
module tb_hart_timer;
  localparam int NH = 4;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0, tick = 0, req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic rsp_err;
  logic [NH-1:0] tmr_irq;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  hart_timer #(.NHARTS(NH), .AW(AW)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #1 e = rsp_err;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    #1 d = rsp_rdata; e = rsp_err;
    req_valid = 0;
  endtask

  logic [31:0] d;
  logic e;

  task automatic t_reset;
    rd(16'h0000, d, e); chk("R1 cmp0 lo", d, 32'hFFFFFFFF);
    rd(16'h001C, d, e); chk("R1 cmp3 hi", d, 32'hFFFFFFFF);
    rd(16'h7FF8, d, e); chk("R1 count lo", d, 0);
    rd(16'h7FFC, d, e); chk("R9 count hi same cycle", d, 0);
    chk("R1 irq", tmr_irq, 0);
  endtask

  task automatic t_tick;
    wr(16'h7FF8, 100, e);
    @(negedge clk); tick = 1;
    repeat (5) @(negedge clk);
    tick = 0;
    rd(16'h7FF8, d, e); chk("R2 five ticks", d, 105);
    @(negedge clk); @(negedge clk);
    rd(16'h7FF8, d, e); chk("R2 hold without tick", d, 105);
  endtask

  task automatic t_priority;
    @(negedge clk);
    tick = 1; req_valid = 1; req_write = 1; req_addr = 16'h7FF8; req_wdata = 500;
    @(negedge clk);
    tick = 0; req_valid = 0; req_write = 0;
    rd(16'h7FF8, d, e); chk("R6 write beats tick", d, 500);
  endtask

  task automatic t_halves;
    wr(16'h7FFC, 32'hA5A5, e);
    rd(16'h7FF8, d, e); chk("R3 low kept", d, 500);
    rd(16'h7FFC, d, e); chk("R3 high written", d, 32'hA5A5);
    wr(16'h7FF8, 7, e);
    rd(16'h7FFC, d, e); chk("R3 high kept", d, 32'hA5A5);
    wr(16'h7FFC, 0, e);
    wr(16'h0010, 32'h1234, e);
    rd(16'h0014, d, e); chk("R4 cmp2 high kept", d, 32'hFFFFFFFF);
    rd(16'h0010, d, e); chk("R4 cmp2 low", d, 32'h1234);
    wr(16'h0014, 32'h55, e);
    rd(16'h0010, d, e); chk("R4 cmp2 low kept", d, 32'h1234);
    wr(16'h0014, 32'hFFFFFFFF, e);
  endtask

  task automatic t_irq;
    wr(16'h7FF8, 1000, e);
    wr(16'h0008, 1500, e);
    wr(16'h000C, 0, e);
    @(negedge clk);
    chk("R5 irq1 below compare", tmr_irq[1], 0);
    wr(16'h7FF8, 1500, e);
    chk("R5 irq1 registered latency", tmr_irq[1], 0);
    @(negedge clk);
    chk("R5 irq1 at equality", tmr_irq[1], 1);
    chk("R5 other harts low", {tmr_irq[3:2], tmr_irq[0]}, 0);
    wr(16'h000C, 1, e);
    @(negedge clk);
    chk("R5 irq1 drops after raise", tmr_irq[1], 0);
    wr(16'h0000, 1499, e);
    wr(16'h0004, 0, e);
    @(negedge clk);
    chk("R5 irq0 above compare", tmr_irq[0], 1);
  endtask

  task automatic t_oow;
    wr(16'h8000, 32'h55, e); chk("R7 write error", e, 1);
    wr(16'hFFFC, 32'h66, e); chk("R7 high write error", e, 1);
    rd(16'h7FF8, d, e); chk("R7 count untouched", d, 1500);
    rd(16'h7FFC, d, e); chk("R7 count hi untouched", d, 0);
    rd(16'h9000, d, e); chk("R7 read error", e, 1); chk("R7 read zero", d, 0);
  endtask

  task automatic t_unused;
    wr(16'h0028, 32'h77, e); chk("R8 write no error", e, 0);
    rd(16'h0028, d, e); chk("R8 reads zero", d, 0); chk("R8 read no error", e, 0);
    rd(16'h0020, d, e); chk("R8 slot4 zero", d, 0);
    chk("R8 irq unaffected", tmr_irq[3:2], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_tick; t_priority; t_halves; t_irq; t_oow; t_unused;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule